// File: doc/BRIEF.md
# Interrupt Destination Match and Lowest-Priority Arbiter

This block decides which of a set of processor agents take an interrupt message. A message carries four things: an 8-bit destination field, a bit that selects physical or logical addressing, a 2-bit shorthand code, and a flag that requests lowest-priority delivery. Each agent supplies three settings. The first is a physical ID. The second is a logical ID. The third is a format bit that makes the logical ID either flat (one bit per agent) or cluster (a cluster number plus a member mask). A global mode pin sets the width of the physical compare: the legacy 4-bit width or the extended 8-bit width.

The block first builds a per-agent accept vector. If the message asks for lowest-priority delivery and uses logical addressing, the block then narrows that vector to one agent. That agent has the smallest task-priority input, and the lower agent index wins a tie.

Messages enter on a valid/ready interface. The rules for back-pressure are as follows:
- An input is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty or is being drained in that same cycle.
- The result appears with `out_valid` on the next clock edge.
- The result stays stable until the cycle where `out_ready` is high.

The agent settings and the mode pin are sampled in the same cycle as the message.

Top module: `irqd_route`

## Requirements
- R1: After reset `out_valid` is 0 and `out_accept` is all zeros, and `in_ready` is 1.
- R2: An accepted input produces `out_valid`=1 with its result on the next clock edge. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_accept` and `out_valid` hold their values.
- R3: The shorthand code selects the target set without looking at the destination field. The codes are: 01 = only the agent whose index equals `in_sender`; 10 = every agent; 11 = every agent except the sender. The destination field is used only with code 00.
- R4: With physical addressing and `ext_phys`=0, an agent matches when destination bits [3:0] equal its physical ID bits [3:0]. Destination bits [7:4] are ignored.
- R5: With physical addressing and `ext_phys`=1, an agent matches only when all 8 destination bits equal its physical ID.
- R6: A physical destination whose compared bits are all ones is a broadcast to every agent. That means a low nibble of 0xF in legacy width, or 0xFF in extended width.
- R7: With logical addressing and flat format (format bit 0), an agent matches when (logical ID AND destination) is nonzero. Several agents can match one message.
- R8: With logical addressing and cluster format (format bit 1), an agent matches when two conditions hold. First, destination bits [7:4] equal logical ID bits [7:4], or equal 0xF. Second, (destination bits [3:0] AND logical ID bits [3:0]) is nonzero.
- R9: When `in_lowpri`=1 and `in_logical`=1, at most one bit of the result is set. That bit belongs to the matching agent with the numerically smallest `task_prio` field. Among equal priorities the lowest index wins.
- R10: When `in_lowpri`=1 and `in_logical`=0, the request is treated as fixed delivery, and every matching agent accepts.
- R11: When no agent matches, `out_accept` is all zeros and `out_valid` is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message present |
| in_ready | output | 1 | Block can take a message |
| in_dest | input | 8 | Destination field |
| in_logical | input | 1 | 1 = logical addressing, 0 = physical |
| in_short | input | 2 | Shorthand code (00 uses destination) |
| in_lowpri | input | 1 | Lowest-priority delivery requested |
| in_sender | input | 3 | Index of the sending agent |
| ext_phys | input | 1 | 1 = 8-bit physical compare, 0 = 4-bit |
| phys_id | input | 64 | Physical ID per agent, agent i at bits [8i+7:8i] |
| log_id | input | 64 | Logical ID per agent, agent i at bits [8i+7:8i] |
| fmt_cluster | input | 8 | Per-agent logical format, 1 = cluster |
| task_prio | input | 32 | Task priority per agent, agent i at bits [4i+3:4i] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_accept | output | 8 | Per-agent accept vector |

## Verification
The bench sends destinations whose upper nibble would hit a different agent if it were compared. A design that used the full 8-bit compare in legacy width would then accept the wrong agent, or none at all. It sends the all-ones nibble in extended mode, where it is not a broadcast. This catches a design that forgot to switch the broadcast width. For lowest-priority delivery it builds a tie on the smallest priority between agents 2 and 4, and it sends a lowest-priority request with physical addressing. A wrong tie-break would pick agent 4, and a design that arbitrated physical requests would return one bit where a full broadcast is expected. It also holds `out_ready` low across several cycles, to catch a result that is overwritten or dropped under back-pressure.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;
endpackage

// File: rtl/irqd_agent_match.sv
module irqd_agent_match #(
  parameter int ID_W  = 8,
  parameter int LEG_W = 4,
  parameter int IDX_W = 3,
  parameter int IDX   = 0
) (
  input  logic [ID_W-1:0]  dest,
  input  logic             logical,
  input  logic [1:0]       short_code,
  input  logic [IDX_W-1:0] sender,
  input  logic             ext_phys,
  input  logic             is_cluster,
  input  logic [ID_W-1:0]  phys_id,
  input  logic [ID_W-1:0]  log_id,
  output logic             hit
);
  import irqd_pkg::*;
  localparam int NIB = ID_W / 2;

  logic is_self;
  logic phys_hit, flat_hit, clus_hit, dest_hit;
  logic [NIB-1:0] clus_dst, clus_own;

  assign is_self  = (sender == IDX_W'(IDX));
  assign clus_dst = dest[ID_W-1:NIB];
  assign clus_own = log_id[ID_W-1:NIB];

  always_comb begin
    if (ext_phys)
      phys_hit = (dest == phys_id) || (&dest);
    else
      phys_hit = (dest[LEG_W-1:0] == phys_id[LEG_W-1:0]) || (&dest[LEG_W-1:0]);
    flat_hit = |(dest & log_id);
    clus_hit = ((clus_dst == clus_own) || (&clus_dst)) &&
               (|(dest[NIB-1:0] & log_id[NIB-1:0]));
    if (!logical)        dest_hit = phys_hit;
    else if (is_cluster) dest_hit = clus_hit;
    else                 dest_hit = flat_hit;
  end

  always_comb begin
    case (shorthand_e'(short_code))
      SH_SELF:   hit = is_self;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !is_self;
      default:   hit = dest_hit;
    endcase
  end
endmodule

// File: rtl/irqd_lowpri_pick.sv
module irqd_lowpri_pick #(
  parameter int N      = 8,
  parameter int PRIO_W = 4
) (
  input  logic [N-1:0]        cand,
  input  logic [N*PRIO_W-1:0] prio,
  output logic [N-1:0]        win
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic              found;
  logic [PRIO_W-1:0] best;
  logic [IDX_W-1:0]  sel;

  always_comb begin
    found = 1'b0;
    best  = '0;
    sel   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best)) begin
        found = 1'b1;
        best  = prio[i*PRIO_W +: PRIO_W];
        sel   = IDX_W'(i);
      end
    end
    win = found ? (N'(1) << sel) : '0;
  end

  always_comb begin
    a_subset_r9: assert ((win & ~cand) == '0);
    a_single_r9: assert ($onehot0(win));
    a_nonempty_r9: assert ((cand == '0) || (win != '0));
  end
endmodule

// File: rtl/irqd_route.sv
module irqd_route #(
  parameter int N_AGENTS = 8,
  parameter int ID_W     = 8,
  parameter int LEG_W    = 4,
  parameter int PRIO_W   = 4,
  localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [ID_W-1:0]            in_dest,
  input  logic                       in_logical,
  input  logic [1:0]                 in_short,
  input  logic                       in_lowpri,
  input  logic [IDX_W-1:0]           in_sender,
  input  logic                       ext_phys,
  input  logic [N_AGENTS*ID_W-1:0]   phys_id,
  input  logic [N_AGENTS*ID_W-1:0]   log_id,
  input  logic [N_AGENTS-1:0]        fmt_cluster,
  input  logic [N_AGENTS*PRIO_W-1:0] task_prio,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [N_AGENTS-1:0]        out_accept
);
  logic [N_AGENTS-1:0] cand, win, result;
  logic                in_fire, arb_q;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    irqd_agent_match #(
      .ID_W(ID_W), .LEG_W(LEG_W), .IDX_W(IDX_W), .IDX(g)
    ) i_match (
      .dest       (in_dest),
      .logical    (in_logical),
      .short_code (in_short),
      .sender     (in_sender),
      .ext_phys   (ext_phys),
      .is_cluster (fmt_cluster[g]),
      .phys_id    (phys_id[g*ID_W +: ID_W]),
      .log_id     (log_id[g*ID_W +: ID_W]),
      .hit        (cand[g])
    );
  end

  irqd_lowpri_pick #(.N(N_AGENTS), .PRIO_W(PRIO_W)) i_pick (
    .cand (cand),
    .prio (task_prio),
    .win  (win)
  );

  assign result   = (in_lowpri && in_logical) ? win : cand;
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= '0;
      arb_q      <= 1'b0;
    end else if (in_fire) begin
      out_valid  <= 1'b1;
      out_accept <= result;
      arb_q      <= in_lowpri && in_logical;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  p_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_accept)));
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_one_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && arb_q) |-> $onehot0(out_accept));
  p_self_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_short == 2'b01) |=> ($countones(out_accept) == 1));
  p_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_short == 2'b10 && !(in_lowpri && in_logical)) |=> (&out_accept));
endmodule

// File: tb/test_irqd_route.sv
`timescale 1ns/1ps
module test_irqd_route;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_dest = '0;
  logic in_logical = 1'b0;
  logic [1:0] in_short = '0;
  logic in_lowpri = 1'b0;
  logic [2:0] in_sender = '0;
  logic ext_phys = 1'b0;
  logic [63:0] phys_id, log_id;
  logic [7:0] fmt_cluster = '0;
  logic [31:0] task_prio;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_accept;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqd_route i_irqd_route (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_logical(in_logical), .in_short(in_short),
    .in_lowpri(in_lowpri), .in_sender(in_sender), .ext_phys(ext_phys),
    .phys_id(phys_id), .log_id(log_id), .fmt_cluster(fmt_cluster),
    .task_prio(task_prio), .out_valid(out_valid), .out_ready(out_ready),
    .out_accept(out_accept)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [7:0] dest;
    logic       logi;
    logic [1:0] sh;
    logic       lp;
    logic [2:0] snd;
    logic       ext;
    logic       cl;
    logic [7:0] exp;
  } vec_t;

  // priorities: a0=3 a1=5 a2=2 a3=7 a4=2 a5=9 a6=4 a7=6
  localparam vec_t VECS [0:21] = '{
    {4'd3,  8'h00, 1'b0, 2'b01, 1'b0, 3'd5, 1'b0, 1'b0, 8'h20}, // R3 self
    {4'd3,  8'h33, 1'b0, 2'b10, 1'b0, 3'd2, 1'b0, 1'b0, 8'hFF}, // R3 all
    {4'd3,  8'h00, 1'b0, 2'b11, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFE}, // R3 others
    {4'd4,  8'hA3, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h08}, // R4 high nibble ignored
    {4'd4,  8'h05, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h20}, // R4
    {4'd5,  8'h43, 1'b0, 2'b00, 1'b0, 3'd0, 1'b1, 1'b0, 8'h08}, // R5
    {4'd5,  8'h03, 1'b0, 2'b00, 1'b0, 3'd0, 1'b1, 1'b0, 8'h00}, // R5 full compare
    {4'd6,  8'h0F, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFF}, // R6 legacy broadcast
    {4'd6,  8'hFF, 1'b0, 2'b00, 1'b0, 3'd0, 1'b1, 1'b0, 8'hFF}, // R6 ext broadcast
    {4'd6,  8'h0F, 1'b0, 2'b00, 1'b0, 3'd0, 1'b1, 1'b0, 8'h00}, // R6 not broadcast ext
    {4'd7,  8'h81, 1'b1, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h81}, // R7
    {4'd11, 8'h00, 1'b1, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00}, // R11
    {4'd8,  8'h13, 1'b1, 2'b00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h30}, // R8
    {4'd8,  8'hF1, 1'b1, 2'b00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h11}, // R8 all clusters
    {4'd8,  8'h2F, 1'b1, 2'b00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h00}, // R8 no cluster 2
    {4'd9,  8'hFF, 1'b1, 2'b00, 1'b1, 3'd0, 1'b0, 1'b0, 8'h04}, // R9 tie a2/a4
    {4'd9,  8'hEB, 1'b1, 2'b00, 1'b1, 3'd0, 1'b0, 1'b0, 8'h01}, // R9
    {4'd9,  8'hEA, 1'b1, 2'b00, 1'b1, 3'd0, 1'b0, 1'b0, 8'h40}, // R9
    {4'd9,  8'h1C, 1'b1, 2'b00, 1'b1, 3'd0, 1'b0, 1'b1, 8'h40}, // R9 cluster
    {4'd10, 8'h0F, 1'b0, 2'b00, 1'b1, 3'd0, 1'b0, 1'b0, 8'hFF}, // R10
    {4'd11, 8'h00, 1'b1, 2'b00, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00}, // R11 lowpri empty
    {4'd9,  8'h00, 1'b1, 2'b10, 1'b1, 3'd6, 1'b0, 1'b0, 8'h04}  // R9 shorthand all
  };

  function automatic void check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  task automatic set_cfg(input logic cl);
    for (int i = 0; i < N; i++) begin
      phys_id[i*8 +: 8] = {4'(i + 1), 4'(i)};
      log_id[i*8 +: 8]  = cl ? {4'(i / 4), 4'(1 << (i % 4))} : 8'(1 << i);
    end
    fmt_cluster = cl ? 8'hFF : 8'h00;
  endtask

  task automatic send(input vec_t v);
    @(negedge clk);
    set_cfg(v.cl);
    in_dest = v.dest; in_logical = v.logi; in_short = v.sh;
    in_lowpri = v.lp; in_sender = v.snd; ext_phys = v.ext;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    task_prio = {4'd6, 4'd4, 4'd9, 4'd2, 4'd7, 4'd2, 4'd5, 4'd3};
    set_cfg(1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(1, {6'd0, out_valid, in_ready}, 8'h01, "reset valid/ready");
    check(1, out_accept, 8'h00, "reset accept");
    rst_n = 1'b1;
    @(negedge clk);
    check(1, {7'd0, out_valid}, 8'h00, "idle after reset");

    for (int k = 0; k < 22; k++) begin
      send(VECS[k]);
      check(2, {7'd0, out_valid}, 8'h01, "valid after fire");
      check(int'(VECS[k].req), out_accept, VECS[k].exp, $sformatf("vector %0d", k));
    end

    // R2 back-pressure hold
    @(negedge clk);
    out_ready = 1'b0;
    send(VECS[3]);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(2, {6'd0, out_valid, in_ready}, 8'h02, "held valid, not ready");
      check(2, out_accept, 8'h08, "held result");
    end
    // a stalled new request must not overwrite
    in_valid = 1'b1; in_short = 2'b10;
    @(negedge clk);
    check(2, out_accept, 8'h08, "no overwrite under stall");
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check(2, {7'd0, out_valid}, 8'h00, "drained");
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule